// File: doc/BRIEF.md
# SPI Mode-3 Master Frame Sequencer

This block is a synchronous serial master for SPI with an idle-high clock that captures data on rising edges and changes it on falling edges. Software-side logic pushes words into an 8-entry transmit queue. While the block is enabled and that queue holds data, the block lowers the select line and shifts each word out most significant bit first. At the same time it collects the same number of bits from the slave into an 8-entry receive queue.

The word length can be set from 4 to 16 bits. The SCK half-period is a whole number of system clocks, never fewer than two. Words that are queued back to back go out as one continuous burst with the select line held low. After the last word, the select line rises one full SCK period after the final capture. The data output has a separate drive-enable signal, so the pad can float while the link is idle.

Top module: `spi_m3_master`

## Requirements
- R1: While not busy, `sck` and `ssel_n` are 1, `mosi_oe` is 0 and `mosi` is 0. `sck` never toggles unless `ssel_n` is low.
- R2: A frame starts only when `enable` is 1 and `tx_empty` is 0. In the cycle the start is seen, `ssel_n` goes to 0 and `mosi_oe` goes to 1, and the head word is removed from the transmit queue.
- R3: Let H be `half_div` if it is 2 or more, and 2 otherwise. The first SCK fall comes H clocks after `ssel_n` falls, and every later SCK edge comes H clocks after the one before it.
- R4: `mosi` changes only together with a falling SCK edge while busy. `miso` is sampled at each rising SCK edge.
- R5: The word length L is `frame_len` clamped to the range 4..16. Each frame carries exactly L bits, with bit L-1 sent first.
- R6: After the final rising edge of a burst, `ssel_n` returns to 1 and `mosi_oe` to 0 exactly 2H clocks later.
- R7: If `enable` is 1 and the transmit queue is not empty when the last high phase of a word ends, the next word's first fall follows H clocks after the final rise. `ssel_n` stays 0 for the whole burst.
- R8: Each received word is pushed into the receive queue right-justified, with the bits above L at 0. `rx_data` shows the oldest entry, and a pulse on `rx_pop` removes it.
- R9: A word that completes while `rx_full` is 1 is dropped and `rx_overrun` is set. `rx_overrun` stays set until an `rx_pop` pulse clears it.
- R10: `busy` is 1 exactly while `ssel_n` is 0.
- R11: Changing `frame_len` or `half_div` while busy has no effect on the burst in progress. Both values are captured when a burst starts.
- R12: If `enable` is cleared while busy, the current word still completes. The block then releases the select line and returns to idle even though the queue still holds words.
- R13: The transmit queue holds 8 words. A push while `tx_full` is 1 is ignored. `tx_full` and `tx_empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| half_div | input | 8 | SCK half-period in system clocks (values below 2 act as 2) |
| frame_len | input | 5 | Bits per word (clamped to 4..16) |
| tx_push | input | 1 | Writes `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit (low L bits used) |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Removes the oldest received word; clears overrun |
| rx_data | output | 16 | Oldest received word, right-justified |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag for a dropped received word |
| busy | output | 1 | High while the select line is asserted |
| sck | output | 1 | Serial clock, idle high |
| ssel_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The hardest cases to reach from the ports involve the decision taken at the end of a word's last high phase. A continuation happens only if a word is queued at that exact point. Clearing `enable` must also land inside a word for it to stop the burst after that word. The stimulus reaches the continuation by pushing a whole burst at full rate right after enabling, so the queue is always ahead of the shifter. It clears `enable` on the cycle after the select line falls, with two more words still queued. Overrun needs nine completed words with no pops in between. The bench gets there by pushing a ninth word once the first has left the transmit queue. A bench slave model drives `miso` on every observed falling edge and times every SCK and select edge against the configured half-period.

// File: rtl/spi_m3_pkg.sv
package spi_m3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } seq_state_t;
endpackage

// File: rtl/spi_m3_fifo.sv
module spi_m3_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/spi_m3_half_timer.sv
module spi_m3_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || cnt == '0) cnt <= reload - DIV_W'(1);
    else                      cnt <= cnt - DIV_W'(1);
  end
endmodule

// File: rtl/spi_m3_seq.sv
module spi_m3_seq
  import spi_m3_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int DIV_W = 8,
  parameter int MIN_LEN = 4,
  parameter int MIN_DIV = 2,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int IDX_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_empty,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             rx_full,
  input  logic             miso,
  input  logic             tick,
  output logic             run,
  output logic [DIV_W-1:0] reload,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [MAX_W-1:0] rx_word,
  output logic             overrun_set,
  output logic             frame_start,
  output logic             word_done,
  output logic             sck,
  output logic             ssel_n,
  output logic             mosi,
  output logic             mosi_oe
);
  seq_state_t       state;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] div_q;
  logic [MAX_W-1:0] txw_q;
  logic [LEN_W-1:0] bitcnt;
  logic [MAX_W-2:0] rx_acc;
  logic [MAX_W-1:0] rx_shift;
  logic             sck_q, ssel_q, mosi_q, oe_q;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
    if (l > LEN_W'(MAX_W))   return LEN_W'(MAX_W);
    return l;
  endfunction

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : d;
  endfunction

  function automatic logic [MAX_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [MAX_W:0] m;
    m = ({{MAX_W{1'b0}}, 1'b1} << l) - (MAX_W + 1)'(1);
    return m[MAX_W-1:0];
  endfunction

  function automatic logic pick_bit(input logic [MAX_W-1:0] w, input logic [LEN_W-1:0] idx);
    return w[idx[IDX_W-1:0]];
  endfunction

  logic more_ready, start_go, lead_done, rise_ev, last_rise;
  logic next_bit, cont_go, trail_go, release_ev;

  assign more_ready = enable && !tx_empty;
  assign start_go   = (state == ST_IDLE) && more_ready;
  assign lead_done  = (state == ST_LEAD) && tick;
  assign rise_ev    = (state == ST_LOW) && tick;
  assign last_rise  = rise_ev && (bitcnt == '0);
  assign next_bit   = (state == ST_HIGH) && tick && (bitcnt != '0);
  assign cont_go    = (state == ST_HIGH) && tick && (bitcnt == '0) && more_ready;
  assign trail_go   = (state == ST_HIGH) && tick && (bitcnt == '0) && !more_ready;
  assign release_ev = (state == ST_TRAIL) && tick;

  assign rx_shift    = {rx_acc, miso};
  assign rx_word     = rx_shift & len_mask(len_q);
  assign tx_pop      = start_go || cont_go;
  assign rx_push     = last_rise && !rx_full;
  assign overrun_set = last_rise && rx_full;
  assign frame_start = lead_done || cont_go;
  assign word_done   = last_rise;

  assign run    = (state != ST_IDLE);
  assign reload = (state == ST_IDLE) ? clamp_div(cfg_div) : div_q;

  assign sck     = sck_q;
  assign ssel_n  = ssel_q;
  assign mosi    = mosi_q;
  assign mosi_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sck_q  <= 1'b1;
      ssel_q <= 1'b1;
      mosi_q <= 1'b0;
      oe_q   <= 1'b0;
      len_q  <= LEN_W'(MIN_LEN);
      div_q  <= DIV_W'(MIN_DIV);
      txw_q  <= '0;
      bitcnt <= '0;
      rx_acc <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_go) begin
          state  <= ST_LEAD;
          ssel_q <= 1'b0;
          oe_q   <= 1'b1;
          mosi_q <= 1'b0;
          txw_q  <= tx_word;
          len_q  <= clamp_len(cfg_len);
          div_q  <= clamp_div(cfg_div);
        end
        ST_LEAD: if (lead_done) begin
          state  <= ST_LOW;
          sck_q  <= 1'b0;
          bitcnt <= len_q - LEN_W'(1);
          mosi_q <= pick_bit(txw_q, len_q - LEN_W'(1));
        end
        ST_LOW: if (rise_ev) begin
          state  <= ST_HIGH;
          sck_q  <= 1'b1;
          rx_acc <= rx_shift[MAX_W-2:0];
        end
        ST_HIGH: begin
          if (next_bit) begin
            state  <= ST_LOW;
            sck_q  <= 1'b0;
            bitcnt <= bitcnt - LEN_W'(1);
            mosi_q <= pick_bit(txw_q, bitcnt - LEN_W'(1));
          end else if (cont_go) begin
            state  <= ST_LOW;
            sck_q  <= 1'b0;
            txw_q  <= tx_word;
            bitcnt <= len_q - LEN_W'(1);
            mosi_q <= pick_bit(tx_word, len_q - LEN_W'(1));
          end else if (trail_go) begin
            state <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (release_ev) begin
          state  <= ST_IDLE;
          ssel_q <= 1'b1;
          oe_q   <= 1'b0;
          mosi_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_m3_master.sv
module spi_m3_master #(
  parameter int MAX_W      = 16,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_div,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             tx_push,
  input  logic [MAX_W-1:0] tx_data,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_pop,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_overrun,
  output logic             busy,
  output logic             sck,
  output logic             ssel_n,
  output logic             mosi,
  output logic             mosi_oe,
  input  logic             miso
);
  logic             tx_pop_w, rx_push_w, overrun_set;
  logic             frame_start, word_done;
  logic             tick, run;
  logic [DIV_W-1:0] reload;
  logic [MAX_W-1:0] tx_head, rx_word;
  logic             ovr_q;

  spi_m3_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
    .pop(tx_pop_w), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_m3_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push_w), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .full(rx_full)
  );

  spi_m3_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .tick(tick)
  );

  spi_m3_seq #(.MAX_W(MAX_W), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_len(frame_len), .cfg_div(half_div),
    .tx_empty(tx_empty), .tx_word(tx_head), .rx_full(rx_full),
    .miso(miso), .tick(tick), .run(run), .reload(reload),
    .tx_pop(tx_pop_w), .rx_push(rx_push_w), .rx_word(rx_word),
    .overrun_set(overrun_set), .frame_start(frame_start), .word_done(word_done),
    .sck(sck), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovr_q <= 1'b0;
    else if (overrun_set) ovr_q <= 1'b1;
    else if (rx_pop)      ovr_q <= 1'b0;
  end

  assign rx_overrun = ovr_q;
  assign busy       = ~ssel_n;
endmodule

// File: rtl/spi_m3_checker.sv
module spi_m3_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_empty,
  input logic tx_full,
  input logic rx_full,
  input logic rx_overrun,
  input logic busy,
  input logic sck,
  input logic ssel_n,
  input logic mosi,
  input logic mosi_oe,
  input logic tx_pop_w,
  input logic word_done
);
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck && ssel_n && !mosi_oe && !mosi));

  assert_sck_only_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> (!ssel_n && !$past(ssel_n)));

  assert_start_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> ($past(enable) && !$past(tx_empty)));

  assert_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> (mosi_oe && sck));

  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));

  assert_release_sck_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssel_n) |-> (sck && $past(sck) && !mosi_oe));

  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full) |=> rx_overrun);

  assert_pop_nonempty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_w |-> !tx_empty);

  assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
endmodule

bind spi_m3_master spi_m3_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_empty(tx_empty),
  .tx_full(tx_full), .rx_full(rx_full), .rx_overrun(rx_overrun),
  .busy(busy), .sck(sck), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe),
  .tx_pop_w(tx_pop_w), .word_done(word_done)
);

// File: tb/spi_m3_master_test.sv
module spi_m3_master_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic [4:0]  frame_len = 5'd8;
  logic        tx_push = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_overrun, busy;
  logic        rx_pop = 1'b0;
  logic [15:0] rx_data;
  logic        sck, ssel_n, mosi, mosi_oe;
  logic        miso = 1'b0;

  spi_m3_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .frame_len(frame_len), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
    .busy(busy), .sck(sck), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe),
    .miso(miso)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_len = 8;
  int exp_h = 2;
  logic [15:0] obs_tx[$];
  logic [15:0] slv_rx[$];
  logic [15:0] exp_tx[$];

  logic prev_sck = 1'b1, prev_ssel = 1'b1, prev_mosi = 1'b0;
  int last_edge = 0, last_rise = 0, bits = 0, frames = 0, ssel_falls = 0;
  logic [15:0] cur_tx = '0, cur_slv = '0;

  function automatic logic [15:0] mask_of(int l);
    return (l >= 16) ? 16'hFFFF : 16'((32'd1 << l) - 1);
  endfunction
  function automatic int clamp_len(int l);
    return (l < 4) ? 4 : ((l > 16) ? 16 : l);
  endfunction
  function automatic int clamp_div(int d);
    return (d < 2) ? 2 : d;
  endfunction
  function automatic logic [15:0] slave_pat(int k);
    return 16'((k * 937) ^ 16'h5C3 ^ (k << 9));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Bench slave and timing monitor.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_ssel && !ssel_n) begin
        ssel_falls++;
        last_edge = cyc;
        bits = 0;
      end
      if (sck != prev_sck) begin
        chk(cyc - last_edge == exp_h, "R3 sck edge spacing", cyc - last_edge, exp_h);
        if (!sck) begin
          if (bits == 0) begin
            frames++;
            cur_slv = slave_pat(frames) & mask_of(exp_len);
            cur_tx = '0;
          end
          miso = cur_slv[exp_len - 1 - bits];
        end else begin
          cur_tx = {cur_tx[14:0], mosi};
          bits++;
          last_rise = cyc;
          if (bits == exp_len) begin
            obs_tx.push_back(cur_tx);
            slv_rx.push_back(cur_slv);
            bits = 0;
          end
        end
        last_edge = cyc;
      end
      if (mosi != prev_mosi && !ssel_n && !prev_ssel && !(prev_sck && !sck))
        chk(1'b0, "R4 mosi moved off a falling edge", mosi, prev_mosi);
      if (!prev_ssel && ssel_n) begin
        chk(cyc - last_rise == 2 * exp_h, "R6 trailing select hold", cyc - last_rise, 2 * exp_h);
        chk(bits == 0, "R5 whole frames only", bits, 0);
        chk(!mosi_oe, "R6 drive released", mosi_oe, 0);
      end
      if (busy != !ssel_n) chk(1'b0, "R10 busy tracks select", busy, !ssel_n);
      prev_sck = sck;
      prev_ssel = ssel_n;
      prev_mosi = mosi;
    end
  end

  task automatic push_word(logic [15:0] d, bit expect_taken);
    @(negedge clk);
    tx_push = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_push = 1'b0;
    if (expect_taken) exp_tx.push_back(d & mask_of(exp_len));
  endtask

  task automatic set_cfg(int lcfg, int dcfg);
    frame_len = 5'(lcfg);
    half_div = 8'(dcfg);
    exp_len = clamp_len(lcfg);
    exp_h = clamp_div(dcfg);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 40000 && quiet < 4; i++) begin
      @(negedge clk);
      if (!busy && (tx_empty || !enable)) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic wait_select();
    for (int i = 0; i < 2000 && ssel_n; i++) @(negedge clk);
  endtask

  task automatic check_tx(string tag);
    chk(obs_tx.size() == exp_tx.size(), {tag, " frame count"}, obs_tx.size(), exp_tx.size());
    while (obs_tx.size() > 0 && exp_tx.size() > 0) begin
      logic [15:0] o, e;
      o = obs_tx.pop_front();
      e = exp_tx.pop_front();
      chk(o == e, {tag, " mosi word"}, o, e);
    end
    obs_tx.delete();
    exp_tx.delete();
  endtask

  task automatic drain_rx(int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      @(negedge clk);
      e = (slv_rx.size() > 0) ? slv_rx.pop_front() : 16'hDEAD;
      chk(!rx_empty, {tag, " rx entry present"}, rx_empty, 0);
      chk(rx_data == e, {tag, " rx word"}, rx_data, e);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
  endtask

  task automatic burst(int n, int lcfg, int dcfg, string tag);
    int f0;
    set_cfg(lcfg, dcfg);
    f0 = ssel_falls;
    enable = 1'b1;
    for (int i = 0; i < n; i++) push_word(16'($urandom), 1'b1);
    wait_idle();
    chk(ssel_falls - f0 == 1, {tag, " R7 one select per burst"}, ssel_falls - f0, 1);
    check_tx(tag);
    drain_rx(n, {tag, " R8"});
    chk(rx_empty, {tag, " R8 rx drained"}, rx_empty, 1);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset levels
    chk(sck && ssel_n && !mosi_oe && !busy, "R1 reset idle levels", {sck, ssel_n, mosi_oe, busy}, 4'b1100);
    chk(tx_empty && !tx_full && rx_empty && !rx_overrun, "R13 reset flags", {tx_empty, tx_full, rx_empty, rx_overrun}, 4'b1010);

    // R2: data queued while disabled does not start a frame
    set_cfg(8, 2);
    push_word(16'h00A5, 1'b1);
    repeat (30) @(negedge clk);
    chk(ssel_n && sck && !mosi_oe, "R2 no start while disabled", {ssel_n, sck, mosi_oe}, 3'b110);
    enable = 1'b1;
    wait_idle();
    check_tx("R2 single word");
    drain_rx(1, "R8 single word");

    // R7: back-to-back burst, 16 bits, H=3
    burst(3, 16, 3, "R7 long burst");
    // R5, R3: clamping of length and divider
    burst(2, 2, 0, "R5 short clamp");
    burst(1, 20, 1, "R5 long clamp");
    burst(2, 0, 4, "R5 zero length");

    // R11: config change in flight
    set_cfg(8, 2);
    enable = 1'b1;
    push_word(16'h1234, 1'b1);
    push_word(16'hABCD, 1'b1);
    wait_select();
    frame_len = 5'd12;
    half_div = 8'd5;
    wait_idle();
    check_tx("R11 locked config");
    drain_rx(2, "R11");
    set_cfg(8, 2);

    // R12: enable dropped mid-word
    enable = 1'b0;
    push_word(16'h0011, 1'b1);
    push_word(16'h0022, 1'b0);
    push_word(16'h0033, 1'b0);
    enable = 1'b1;
    wait_select();
    @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy && ssel_n && sck && !mosi_oe, "R12 idle after stop", {busy, ssel_n, sck, mosi_oe}, 4'b0110);
    chk(!tx_empty, "R12 words left queued", tx_empty, 0);
    check_tx("R12 one word only");
    drain_rx(1, "R12");
    exp_tx.push_back(16'h0022 & mask_of(exp_len));
    exp_tx.push_back(16'h0033 & mask_of(exp_len));
    enable = 1'b1;
    wait_idle();
    check_tx("R12 resumed");
    drain_rx(2, "R12 resumed");

    // R13: transmit queue capacity
    enable = 1'b0;
    set_cfg(4, 2);
    for (int i = 0; i < 9; i++) push_word(16'(i + 1), i < 8);
    chk(tx_full && !tx_empty, "R13 full after eight", {tx_full, tx_empty}, 2'b10);
    enable = 1'b1;
    wait_idle();
    check_tx("R13 ninth push ignored");
    drain_rx(8, "R13");

    // R9: overrun with nine frames and no pops
    set_cfg(4, 2);
    for (int i = 0; i < 9; i++) push_word(16'(i * 3 + 5), 1'b1);
    wait_idle();
    check_tx("R9 frames sent");
    chk(rx_full && rx_overrun, "R9 overrun set", {rx_full, rx_overrun}, 2'b11);
    drain_rx(1, "R9 kept");
    chk(!rx_overrun, "R9 overrun cleared by pop", rx_overrun, 0);
    drain_rx(7, "R9 kept");
    chk(rx_empty, "R9 dropped word absent", rx_empty, 1);
    void'(slv_rx.pop_front());

    // Random bursts
    for (int r = 0; r < 8; r++)
      burst(int'($urandom_range(1, 4)), int'($urandom_range(4, 16)), int'($urandom_range(2, 5)), "R3 random");

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule